// File: doc/BRIEF.md
# External Bus Yield Controller

This block decides when the processor hands its external memory bus to another bus master. Another master asks for the bus with an asynchronous request line. The block waits until no external access is running, then raises grant, turns off the address, data and strobe drivers, and halts the core. It reverses all of these when the request goes away.

The block keeps the bus while an external access is in flight. An instruction that makes two external accesses can still lose the bus in the idle cycle between them. In run-on mode the core keeps executing while another master holds the bus, and it halts only when it has an external access to make. A separate status output shows that the stopped processor is waiting for the bus for a memory access or a boot-DMA access. Request handling stays active while reset is asserted.

Top module: `ext_bus_yield`

## Requirements
- R1: With no access in progress, a request that rises before clock edge 1 produces grant high after edge SYNC_STAGES+1 (edge 3 by default). In that same cycle the driver enable is low and, when run-on mode is off, halt is high.
- R2: While `xfer_active_i` is high, grant stays low. If the request is already synchronized, grant rises at the first edge where `xfer_active_i` is low. If the access outlasts the synchronizer, that is the edge after the access's last busy edge.
- R3: For an instruction making two accesses separated by one idle cycle, grant is taken at the edge of that idle cycle, before the second access starts.
- R4: With `go_mode_i` high and `xfer_pending_i` low, halt stays low while grant is high. One edge after `xfer_pending_i` rises, halt is high.
- R5: When the request falls, grant, halt and wait all go low after edge SYNC_STAGES+1, and the driver enable goes high in that same cycle.
- R6: While `rst` is high, a request is still granted after SYNC_STAGES+1 edges, even with `xfer_active_i` high. During reset, halt follows grant.
- R7: `wait_bus_o` is high exactly in the cycles after an edge at which the bus was granted and `xfer_pending_i` was high, outside reset.
- R8: After reset with the request low, grant, halt and wait are low and the driver enable is high.
- R9: The driver enable is never high while grant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset; arbitration keeps running |
| bus_req_i | input | 1 | Asynchronous bus request from another master |
| xfer_active_i | input | 1 | An external memory access is in progress this cycle |
| xfer_pending_i | input | 1 | Core or boot DMA needs an external access that has not started |
| go_mode_i | input | 1 | Keep the core running while the bus is lent out |
| grant_o | output | 1 | Bus granted to the other master |
| drv_en_o | output | 1 | Enable for address, data and strobe drivers |
| core_halt_o | output | 1 | Stop the core |
| wait_bus_o | output | 1 | Stopped processor needs the bus back for a pending access |

## Verification
The hardest case to reach is the one-cycle gap between the two accesses of a single instruction. The request must already be through the synchronizer and held back by a long busy period, so that the only legal grant point is the single idle edge. The bench holds `xfer_active_i` high past the synchronizer delay, drops it for one cycle, and expects grant exactly then. A sweep over busy lengths, run-on mode and pending state checks that the grant edge equals the later of the synchronizer delay and the end of the access.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  typedef struct packed {
    logic grant;
    logic drv_en;
    logic halt;
    logic wait_bus;
  } ebr_out_t;

  localparam int unsigned EBR_MIN_SYNC = 2;
endpackage

// File: rtl/ebr_sync.sv
module ebr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) pipe_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk) pipe_q <= {pipe_q[LAST-1:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[LAST];
endmodule

// File: rtl/ebr_grant_core.sv
module ebr_grant_core (
  input  logic clk,
  input  logic rst,
  input  logic req_s_i,
  input  logic xfer_active_i,
  output logic grant_d_o,
  output logic grant_q_o
);
  logic grant_q;

  // grant may only be taken when the bus is idle; once held it is kept
  // while the request stays up. In reset no access can be running.
  assign grant_d_o = req_s_i && (rst || grant_q || !xfer_active_i);

  always_ff @(posedge clk) grant_q <= grant_d_o;

  assign grant_q_o = grant_q;

  AST_NO_GRANT_MID_XFER: assert property (@(posedge clk) disable iff (rst)
    (!grant_q && xfer_active_i) |=> !grant_q_o); // R2

  AST_GRANT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (req_s_i && !xfer_active_i) |=> grant_q_o); // R1
endmodule

// File: rtl/ebr_out_stage.sv
module ebr_out_stage
  import ebr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     grant_d_i,
  input  logic     go_mode_i,
  input  logic     xfer_pending_i,
  output ebr_out_t out_o
);
  logic drv_q, halt_q, wait_q;

  always_ff @(posedge clk) begin
    drv_q  <= !grant_d_i;
    halt_q <= grant_d_i && (rst || !go_mode_i || xfer_pending_i);
    wait_q <= grant_d_i && xfer_pending_i && !rst;
  end

  always_comb begin
    out_o          = '0;
    out_o.drv_en   = drv_q;
    out_o.halt     = halt_q;
    out_o.wait_bus = wait_q;
  end

  AST_RUN_ON_NO_HALT: assert property (@(posedge clk) disable iff (rst)
    (grant_d_i && go_mode_i && !xfer_pending_i) |=> !out_o.halt); // R4

  AST_WAIT_RAISE: assert property (@(posedge clk) disable iff (rst)
    (grant_d_i && xfer_pending_i) |=> out_o.wait_bus); // R7
endmodule

// File: rtl/ext_bus_yield.sv
module ext_bus_yield
  import ebr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_req_i,
  input  logic xfer_active_i,
  input  logic xfer_pending_i,
  input  logic go_mode_i,
  output logic grant_o,
  output logic drv_en_o,
  output logic core_halt_o,
  output logic wait_bus_o
);
  localparam int unsigned STAGES_EFF =
    (SYNC_STAGES < EBR_MIN_SYNC) ? EBR_MIN_SYNC : SYNC_STAGES;

  logic     req_s;
  logic     grant_d, grant_q;
  ebr_out_t outs;

  ebr_sync #(.STAGES(STAGES_EFF)) i_sync (
    .clk (clk),
    .d_i (bus_req_i),
    .q_o (req_s)
  );

  ebr_grant_core i_core (
    .clk           (clk),
    .rst           (rst),
    .req_s_i       (req_s),
    .xfer_active_i (xfer_active_i),
    .grant_d_o     (grant_d),
    .grant_q_o     (grant_q)
  );

  ebr_out_stage i_out (
    .clk            (clk),
    .rst            (rst),
    .grant_d_i      (grant_d),
    .go_mode_i      (go_mode_i),
    .xfer_pending_i (xfer_pending_i),
    .out_o          (outs)
  );

  assign grant_o     = grant_q;
  assign drv_en_o    = outs.drv_en;
  assign core_halt_o = outs.halt;
  assign wait_bus_o  = outs.wait_bus;

  AST_DRV_OFF_IN_GRANT: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> !drv_en_o); // R9

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (grant_o && !req_s) |=> (!grant_o && drv_en_o && !core_halt_o)); // R5

  AST_WAIT_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    wait_bus_o |-> grant_o); // R7
endmodule

// File: tb/test_ext_bus_yield.sv
module test_ext_bus_yield;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst, req, xact, pend, go;
  logic grant, drv, halt, waitb;
  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;

  always #2.5 clk = ~clk;

  ext_bus_yield #(.SYNC_STAGES(SYNC)) i_ext_bus_yield (
    .clk(clk), .rst(rst), .bus_req_i(req), .xfer_active_i(xact),
    .xfer_pending_i(pend), .go_mode_i(go), .grant_o(grant),
    .drv_en_o(drv), .core_halt_o(halt), .wait_bus_o(waitb)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_bus();
    int e;
    req = 1'b0;
    e = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (!grant && e == 0) e = k;
    end
    chk("R5 release edge", e, LAT);
    chk("R5 drv back", drv, 1);
    chk("R5 halt off", halt, 0);
    chk("R5 wait off", waitb, 0);
    pend = 1'b0;
    edges(2);
  endtask

  initial begin
    rst = 1'b1; req = 1'b0; xact = 1'b0; pend = 1'b0; go = 1'b0;
    edges(6);
    rst = 1'b0;
    edges(1);
    chk("R8 grant", grant, 0);
    chk("R8 drv", drv, 1);
    chk("R8 halt", halt, 0);
    chk("R8 wait", waitb, 0);

    // R1 R2 R7 R9 sweep over run-on mode, pending and busy length
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < 2; p++) begin
        for (int d = 0; d <= 5; d++) begin
          int first, expg;
          bit drv_bad;
          go = g[0]; pend = p[0];
          req = 1'b1; xact = (d > 0);
          first = 0; drv_bad = 0;
          expg = (d + 1 > LAT) ? d + 1 : LAT;
          for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k == d) xact = 1'b0;
            if (grant && drv) drv_bad = 1;
            if (grant && first == 0) begin
              first = k;
              chk("R1 halt at grant", halt, (g == 0 || p == 1) ? 1 : 0);
              chk("R7 wait at grant", waitb, p);
            end
          end
          chk(d == 0 ? "R1 grant edge" : "R2 grant edge", first, expg);
          chk("R9 drv vs grant", drv_bad, 0);
          release_bus();
        end
      end
    end

    // R3: two accesses with one idle cycle between them
    go = 1'b0; pend = 1'b0;
    req = 1'b1; xact = 1'b1;
    edges(6);
    chk("R3 held during first access", grant, 0);
    xact = 1'b0;
    pend = 1'b1;
    edges(1);
    chk("R3 grant in gap", grant, 1);
    chk("R3 drv off", drv, 0);
    edges(1);
    chk("R7 wait for second access", waitb, 1);
    release_bus();

    // R4: run-on mode halts only once an access is needed
    go = 1'b1; pend = 1'b0; req = 1'b1;
    edges(LAT + 2);
    chk("R4 granted", grant, 1);
    chk("R4 no halt", halt, 0);
    chk("R7 no wait", waitb, 0);
    pend = 1'b1;
    edges(1);
    chk("R4 halt after pending", halt, 1);
    chk("R7 wait after pending", waitb, 1);
    release_bus();
    go = 1'b0;

    // R6: grant works during reset even with an access flagged
    rst = 1'b1; xact = 1'b1; req = 1'b1;
    edges(LAT);
    chk("R6 grant in reset", grant, 1);
    chk("R6 halt in reset", halt, 1);
    chk("R6 drv off in reset", drv, 0);
    req = 1'b0;
    edges(LAT);
    chk("R6 release in reset", grant, 0);
    chk("R6 drv back in reset", drv, 1);
    rst = 1'b0; xact = 1'b0;
    edges(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule